// File: doc/BRIEF.md
# PLL Scan-Chain Reconfiguration Sequencer

This block reprograms a PLL while the chip runs, by writing a fresh configuration image into the PLL's serial scan chain. A requester sets a 4-bit frequency code and pulses `start`. The block takes the matching 144-bit image from a built-in constant ROM. It shifts the image out one bit per cycle while it gates the scan clock on, and then issues a single-cycle update strobe. It then waits for the PLL to report that the scan is complete, and finally gives the PLL a one-cycle asynchronous reset so that it relocks on the new settings.

The fifteen valid codes select output frequencies from 72 MHz up in 2 MHz steps to 100 MHz. Code 15 has no profile. Completion is detected from the level of scan-done, so the sequencer still works when that signal never falls between reconfigurations. A programmable watchdog ends a sequence whose scan-done never arrives. The requester sees `busy` for the whole sequence, a one-cycle `done`, and one-cycle error pulses for a bad code or a timeout. Every output is driven straight from a flop on the rising edge of `clk`.

Top module: `pllrc_seq`

## Requirements
- R1: A valid sequence holds `scan_clk_en` high for exactly 144 consecutive cycles, starting two cycles after the cycle in which `start` was accepted. It is low at all other times.
- R2: During those 144 cycles `scan_data` presents image bit 143 first and bit 0 last, one bit per cycle.
- R3: The image for code k (0 to 14, frequency 72+2k MHz) is built from a 9-bit word W = {k[3:0], (3k+1) mod 32 as 5 bits}. Image bit i equals W[i mod 9].
- R4: After the last shifted bit there is exactly one cycle with neither output active. `cfg_update` is then high for exactly one cycle, and only once per sequence.
- R5: From the cycle after `cfg_update`, `scan_done` is sampled each cycle. `pll_areset` is high for exactly one cycle, namely the cycle after the first such cycle in which `scan_done` is high. A `scan_done` that was already high and stays high counts.
- R6: `done` is high for exactly one cycle, the cycle after `pll_areset`. `busy` is high from the cycle after the accepted `start` up to and including the `done` cycle, and low after it.
- R7: `start` is accepted only while idle. A `start` pulse or a `freq_sel` change during a sequence has no effect: the image shifted is the one selected at acceptance, and no second sequence follows.
- R8: `start` with code 15 gives a one-cycle `err_sel` pulse in the next cycle. `busy` stays low and nothing is shifted.
- R9: If `scan_done` stays low for max(`tmo_limit`,1) sampled cycles after the update, `err_tmo` pulses for one cycle. `pll_areset` is never raised, and `busy` drops with the error pulse.
- R10: While `rst` is high and in the cycle after it, every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reconfiguration clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request a reconfiguration |
| freq_sel | input | 4 | Frequency code, sampled with an accepted start |
| tmo_limit | input | 16 | Cycles to wait for scan-done before giving up |
| scan_done | input | 1 | Scan-complete indication from the PLL |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| err_sel | output | 1 | One-cycle pulse: code has no profile |
| err_tmo | output | 1 | One-cycle pulse: scan-done never arrived |
| scan_data | output | 1 | Serial image bit to the PLL |
| scan_clk_en | output | 1 | Scan-clock enable to the PLL |
| cfg_update | output | 1 | Configuration-update strobe |
| pll_areset | output | 1 | PLL asynchronous reset pulse |

## Verification
The hardest case to reach is a scan-done that is already high before the update and never falls. In that case the reset must follow the update with no wait. If the logic relied on an edge of scan-done, it would hang. The bench reaches this state by running a normal sequence first, in which its PLL stand-in raises scan-done. It then switches the stand-in to a mode that never clears the flag and starts a second sequence. Restarts and code changes in the middle of shifting are applied at a fixed cycle of the shift window. The bench then checks that the captured image matches the originally selected code.

// File: rtl/pllrc_pkg.sv
package pllrc_pkg;
    localparam int IMG_W    = 144;
    localparam int SEL_W    = 4;
    localparam int NUM_PROF = 15;
    localparam int WORD_W   = 9;
    localparam int LOW_W    = WORD_W - SEL_W;
    localparam int TMO_W    = 16;

    typedef enum logic [2:0] {
        ST_IDLE, ST_PREP, ST_SHIFT, ST_GAP, ST_UPD, ST_WAIT, ST_RST, ST_DONE
    } seq_st_e;

    typedef struct packed {
        logic data;
        logic clk_en;
        logic update;
        logic areset;
    } pll_drv_t;

    typedef struct packed {
        logic busy;
        logic done;
        logic err_sel;
        logic err_tmo;
    } req_stat_t;

    function automatic logic [WORD_W-1:0] profile_word(int k);
        return {SEL_W'(k), LOW_W'((3 * k + 1) % 32)};
    endfunction
endpackage

// File: rtl/pllrc_rom.sv
module pllrc_rom
    import pllrc_pkg::*;
#(
    parameter int P_IMG_W    = IMG_W,
    parameter int P_SEL_W    = SEL_W,
    parameter int P_NUM_PROF = NUM_PROF
) (
    input  logic [P_SEL_W-1:0] sel,
    output logic [P_IMG_W-1:0] img,
    output logic               valid
);
    localparam int N_ENT = 2 ** P_SEL_W;

    logic [P_IMG_W-1:0] prof_tbl [N_ENT];

    for (genvar p = 0; p < N_ENT; p++) begin : g_prof
        localparam logic [WORD_W-1:0] W = profile_word(p);
        for (genvar b = 0; b < P_IMG_W; b++) begin : g_bit
            if (p < P_NUM_PROF) begin : g_on
                assign prof_tbl[p][b] = W[b % WORD_W];
            end else begin : g_off
                assign prof_tbl[p][b] = 1'b0;
            end
        end
    end

    assign valid = (32'(sel) < P_NUM_PROF);
    assign img   = valid ? prof_tbl[sel] : '0;
endmodule

// File: rtl/pllrc_shift.sv
module pllrc_shift
    import pllrc_pkg::*;
#(
    parameter int P_IMG_W = IMG_W,
    localparam int CNT_W  = $clog2(P_IMG_W + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic               adv,
    input  logic [P_IMG_W-1:0] img,
    output logic               bit_o,
    output logic               last
);
    logic [P_IMG_W-1:0] sr;
    logic [CNT_W-1:0]   cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            sr  <= '0;
            cnt <= '0;
        end else if (load) begin
            sr  <= img;
            cnt <= '0;
        end else if (adv) begin
            sr  <= {sr[P_IMG_W-2:0], 1'b0};
            cnt <= cnt + 1'b1;
        end
    end

    assign bit_o = sr[P_IMG_W-1];
    assign last  = (cnt == CNT_W'(P_IMG_W));

    a_r1_count_bound: assert property (@(posedge clk) disable iff (rst)
        32'(cnt) <= P_IMG_W);
    a_r1_no_shift_past_end: assert property (@(posedge clk) disable iff (rst)
        last |-> !adv);
endmodule

// File: rtl/pllrc_timer.sv
module pllrc_timer #(
    parameter int P_TMO_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               run,
    input  logic [P_TMO_W-1:0] limit,
    output logic               hit
);
    logic [P_TMO_W:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run) cnt <= '0;
        else if (!hit)   cnt <= cnt + 1'b1;
    end

    assign hit = run && ((cnt + 1'b1) >= {1'b0, limit});

    a_r9_count_only_when_running: assert property (@(posedge clk) disable iff (rst)
        !run |=> (cnt == '0));
endmodule

// File: rtl/pllrc_ctrl.sv
module pllrc_ctrl
    import pllrc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      start,
    input  logic      sel_ok,
    input  logic      scan_done,
    input  logic      sh_bit,
    input  logic      sh_last,
    input  logic      tmo_hit,
    output logic      sh_load,
    output logic      sh_adv,
    output logic      tmr_run,
    output pll_drv_t  drv,
    output req_stat_t stat
);
    seq_st_e st, nxt;
    logic    bad_sel, tmo_fire;

    always_comb begin
        nxt      = st;
        sh_load  = 1'b0;
        sh_adv   = 1'b0;
        bad_sel  = 1'b0;
        tmo_fire = 1'b0;
        unique case (st)
            ST_IDLE: if (start) begin
                if (sel_ok) begin
                    nxt     = ST_PREP;
                    sh_load = 1'b1;
                end else begin
                    bad_sel = 1'b1;
                end
            end
            ST_PREP: begin
                nxt    = ST_SHIFT;
                sh_adv = 1'b1;
            end
            ST_SHIFT: begin
                if (sh_last) nxt = ST_GAP;
                else         sh_adv = 1'b1;
            end
            ST_GAP: nxt = ST_UPD;
            ST_UPD: nxt = ST_WAIT;
            ST_WAIT: begin
                if (scan_done) begin
                    nxt = ST_RST;
                end else if (tmo_hit) begin
                    nxt      = ST_IDLE;
                    tmo_fire = 1'b1;
                end
            end
            ST_RST:  nxt = ST_DONE;
            ST_DONE: nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    assign tmr_run = (st == ST_WAIT);

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= ST_IDLE;
            drv  <= '0;
            stat <= '0;
        end else begin
            st           <= nxt;
            drv.data     <= sh_adv ? sh_bit : 1'b0;
            drv.clk_en   <= sh_adv;
            drv.update   <= (nxt == ST_UPD);
            drv.areset   <= (nxt == ST_RST);
            stat.busy    <= (nxt != ST_IDLE);
            stat.done    <= (nxt == ST_DONE);
            stat.err_sel <= bad_sel;
            stat.err_tmo <= tmo_fire;
        end
    end

    a_r4_update_after_gap: assert property (@(posedge clk) disable iff (rst)
        $fell(drv.clk_en) |=> drv.update);
    a_r4_update_single: assert property (@(posedge clk) disable iff (rst)
        drv.update |=> !drv.update);
    a_r5_areset_single: assert property (@(posedge clk) disable iff (rst)
        drv.areset |=> !drv.areset);
    a_r5_areset_needs_done: assert property (@(posedge clk) disable iff (rst)
        $rose(drv.areset) |-> $past(scan_done));
    a_r6_done_follows_areset: assert property (@(posedge clk) disable iff (rst)
        drv.areset |=> stat.done);
    a_r1_shift_inside_busy: assert property (@(posedge clk) disable iff (rst)
        drv.clk_en |-> stat.busy);
    a_r8_reject_stays_idle: assert property (@(posedge clk) disable iff (rst)
        stat.err_sel |-> !stat.busy && !drv.clk_en);
    a_r9_timeout_no_reset: assert property (@(posedge clk) disable iff (rst)
        stat.err_tmo |-> !drv.areset && !stat.busy);
    a_r2_data_quiet_off: assert property (@(posedge clk) disable iff (rst)
        !drv.clk_en |-> !drv.data);
endmodule

// File: rtl/pllrc_seq.sv
module pllrc_seq
    import pllrc_pkg::*;
#(
    parameter int P_IMG_W    = IMG_W,
    parameter int P_SEL_W    = SEL_W,
    parameter int P_NUM_PROF = NUM_PROF,
    parameter int P_TMO_W    = TMO_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [P_SEL_W-1:0] freq_sel,
    input  logic [P_TMO_W-1:0] tmo_limit,
    input  logic               scan_done,
    output logic               busy,
    output logic               done,
    output logic               err_sel,
    output logic               err_tmo,
    output logic               scan_data,
    output logic               scan_clk_en,
    output logic               cfg_update,
    output logic               pll_areset
);
    logic [P_IMG_W-1:0] img;
    logic               sel_ok, sh_load, sh_adv, sh_bit, sh_last, tmr_run, tmo_hit;
    pll_drv_t           drv;
    req_stat_t          stat;

    pllrc_rom #(.P_IMG_W(P_IMG_W), .P_SEL_W(P_SEL_W), .P_NUM_PROF(P_NUM_PROF)) u_rom (
        .sel(freq_sel), .img(img), .valid(sel_ok)
    );

    pllrc_shift #(.P_IMG_W(P_IMG_W)) u_shift (
        .clk(clk), .rst(rst), .load(sh_load), .adv(sh_adv),
        .img(img), .bit_o(sh_bit), .last(sh_last)
    );

    pllrc_timer #(.P_TMO_W(P_TMO_W)) u_timer (
        .clk(clk), .rst(rst), .run(tmr_run), .limit(tmo_limit), .hit(tmo_hit)
    );

    pllrc_ctrl u_ctrl (
        .clk(clk), .rst(rst), .start(start), .sel_ok(sel_ok),
        .scan_done(scan_done), .sh_bit(sh_bit), .sh_last(sh_last),
        .tmo_hit(tmo_hit), .sh_load(sh_load), .sh_adv(sh_adv),
        .tmr_run(tmr_run), .drv(drv), .stat(stat)
    );

    assign scan_data   = drv.data;
    assign scan_clk_en = drv.clk_en;
    assign cfg_update  = drv.update;
    assign pll_areset  = drv.areset;
    assign busy        = stat.busy;
    assign done        = stat.done;
    assign err_sel     = stat.err_sel;
    assign err_tmo     = stat.err_tmo;
endmodule

// File: tb/test_pllrc_seq.sv
module test_pllrc_seq;
    localparam int CLK_PERIOD = 10;
    localparam int IW = 144;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [3:0]  freq_sel = '0;
    logic [15:0] tmo_limit = 16'd100;
    logic        sd;
    logic        busy, done, err_sel, err_tmo, scan_data, scan_clk_en, cfg_update, pll_areset;

    int n_chk = 0, n_fail = 0, cyc = 0, sd_mode = 0;
    bit finished = 1'b0;
    logic [IW-1:0] cap;
    int cd;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    pllrc_seq i_pllrc_seq (
        .clk(clk), .rst(rst), .start(start), .freq_sel(freq_sel), .tmo_limit(tmo_limit),
        .scan_done(sd), .busy(busy), .done(done), .err_sel(err_sel), .err_tmo(err_tmo),
        .scan_data(scan_data), .scan_clk_en(scan_clk_en), .cfg_update(cfg_update),
        .pll_areset(pll_areset)
    );

    // PLL stand-in: mode 0 clears scan-done when shifting starts, mode 1 never clears it, mode 2 holds it low
    always @(posedge clk) begin
        if (rst) begin
            cap <= '0; sd <= 1'b0; cd <= 0;
        end else begin
            if (scan_clk_en) cap <= {cap[IW-2:0], scan_data};
            if (sd_mode == 2) sd <= 1'b0;
            else begin
                if (sd_mode == 0 && scan_clk_en) sd <= 1'b0;
                if (cfg_update) cd <= 3;
                else if (cd != 0) begin
                    cd <= cd - 1;
                    if (cd == 1) sd <= 1'b1;
                end
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [IW-1:0] exp_image(input int k);
        logic [8:0] w;
        logic [IW-1:0] r;
        w = {4'(k), 5'((3 * k + 1) % 32)};
        for (int i = 0; i < IW; i++) r[i] = w[i % 9];
        return r;
    endfunction

    task automatic run_seq(input int code, input int mode, input int lim, input bit disturb);
        int sc, first_en = -1, last_en = -1, n_en = 0, upd = -1, n_upd = 0, sdc = -1;
        int ar = -1, n_ar = 0, dn = -1, n_dn = 0, n_busy = 0, tmo = -1, esel = -1, stop_at = -1;
        int eff;
        @(negedge clk);
        sd_mode = mode; tmo_limit = 16'(lim); freq_sel = 4'(code); start = 1'b1; sc = cyc;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 700; i++) begin
            if (busy) n_busy++;
            if (scan_clk_en) begin
                if (first_en < 0) first_en = cyc;
                last_en = cyc; n_en++;
            end
            if (cfg_update) begin if (upd < 0) upd = cyc; n_upd++; end
            if (upd >= 0 && cyc > upd && sd && sdc < 0) sdc = cyc;
            if (pll_areset) begin if (ar < 0) ar = cyc; n_ar++; end
            if (done) begin if (dn < 0) dn = cyc; n_dn++; end
            if (err_tmo && tmo < 0) tmo = cyc;
            if (err_sel && esel < 0) esel = cyc;
            if (stop_at < 0 && (dn >= 0 || tmo >= 0 || esel >= 0)) stop_at = cyc + 4;
            if (disturb && i == 30) begin freq_sel = 4'd3; start = 1'b1; end
            if (disturb && i == 31) start = 1'b0;
            if (stop_at >= 0 && cyc >= stop_at) break;
            @(negedge clk);
        end
        check(!busy, "R6 busy low after sequence", busy, 0);
        if (code >= 15) begin
            check(esel == sc + 1, "R8 err_sel cycle", esel, sc + 1);
            check(n_en == 0, "R8 nothing shifted", n_en, 0);
            check(n_busy == 0, "R8 busy stays low", n_busy, 0);
            check(n_upd == 0, "R8 no update", n_upd, 0);
        end else begin
            check(n_en == IW, "R1 enable cycles", n_en, IW);
            check(first_en == sc + 2, "R1 first enable cycle", first_en, sc + 2);
            check(last_en == first_en + IW - 1, "R1 enable contiguous", last_en, first_en + IW - 1);
            check(cap == exp_image(code), "R2 R3 captured image (lsbs)", int'(cap[31:0]),
                  int'(exp_image(code) >> 0));
            check(upd == last_en + 2, "R4 update after one-cycle gap", upd, last_en + 2);
            check(n_upd == 1, "R4 single update", n_upd, 1);
            if (disturb) check(n_upd == 1 && cap == exp_image(code), "R7 disturbance ignored", n_upd, 1);
            if (mode == 2) begin
                eff = (lim < 1) ? 1 : lim;
                check(tmo == upd + 1 + eff, "R9 timeout cycle", tmo, upd + 1 + eff);
                check(n_ar == 0, "R9 no reset on timeout", n_ar, 0);
                check(n_dn == 0, "R9 no done on timeout", n_dn, 0);
            end else begin
                check(ar == sdc + 1, "R5 reset after scan-done", ar, sdc + 1);
                check(n_ar == 1, "R5 single reset cycle", n_ar, 1);
                check(dn == ar + 1, "R6 done after reset", dn, ar + 1);
                check(n_dn == 1, "R6 single done", n_dn, 1);
                check(n_busy == dn - sc, "R6 busy span", n_busy, dn - sc);
            end
        end
    endtask

    task automatic t_reset;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check({busy, done, err_sel, err_tmo, scan_data, scan_clk_en, cfg_update, pll_areset} == 8'h0,
              "R10 outputs low in reset", 1, 0);
        rst = 1'b0;
        @(negedge clk);
        check({busy, done, err_sel, err_tmo, scan_data, scan_clk_en, cfg_update, pll_areset} == 8'h0,
              "R10 outputs low after reset", 1, 0);
    endtask

    task automatic t_basic;        run_seq(0, 0, 100, 1'b0); run_seq(9, 0, 100, 1'b0); endtask
    task automatic t_stuck_done;   run_seq(14, 1, 100, 1'b0); endtask
    task automatic t_disturb;      run_seq(7, 0, 100, 1'b1); endtask
    task automatic t_reject;       run_seq(15, 0, 100, 1'b0); endtask
    task automatic t_timeout;      run_seq(5, 2, 5, 1'b0); run_seq(2, 2, 0, 1'b0); endtask
    task automatic t_after_timeout; run_seq(11, 0, 100, 1'b0); endtask

    initial begin
        t_reset();
        t_basic();
        t_stuck_done();
        t_disturb();
        t_reject();
        t_timeout();
        t_after_timeout();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule